// File: doc/BRIEF.md
# Address-Multiplexed DRAM Controller with Row Refresh

This block sits between a synchronous request stream and a dynamic memory array of 2048 rows by 2048 columns of 4-bit cells, 4M words in all. A 22-bit word address is split into an 11-bit row (upper half) and an 11-bit column (lower half). Both halves go out in turn on one 11-line address bus. A row strobe qualifies the row half and a column strobe then qualifies the column half. A write-enable line and a read-enable line choose the direction of the column phase.

Reading drains the sensed cell. After every read the controller drives the captured value back into the same column while the row is still open, and only then closes the row. A programmable interval timer requests one row refresh per tick. A refresh is a row-strobe-only cycle on the row named by an internal counter, which then advances. A pending refresh waits for the current access to finish and then goes ahead of any new request.

The request side follows valid/ready rules. A transfer happens on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle and no refresh is pending. A requester facing low `req_ready` must hold `req_valid` and all request fields steady. Read data has no back-pressure: it appears for exactly one cycle with `rsp_valid`.

Top module: `dram_ctrl`

## Requirements
- R1: After reset, both strobes, the write enable and the read enable are inactive (high), `dq_oe` and `rsp_valid` are low, and `req_ready` is high once `refresh_interval` is 0.
- R2: A request to address A opens row A[21:11] on `mem_addr` with `row_stb_n` low, then presents column A[10:0] with `col_stb_n` low while `row_stb_n` stays low.
- R3: `req_ready` drops once a request is accepted and stays low until that access has closed its row; a request held valid through back-pressure is accepted exactly once.
- R4: A write presents its data on `dq_o` with `dq_oe` high and `wr_en_n` low during its column phase; a later read of the same address returns that data.
- R5: A read drives `rd_en_n` low in its column phase, samples `dq_i` at the end of that cycle, and returns the value on `rsp_rdata` with `rsp_valid` high for exactly one cycle, the cycle after that column phase.
- R6: Every read is followed, in the same row opening, by a column write of the sensed value to the same column, so repeated reads of one address all return the written data.
- R7: With `refresh_interval` N > 0, a refresh is requested every N cycles. Each refresh opens and closes a row without any column strobe, using the internal row counter, which starts at 0 after reset, steps by one per refresh and wraps from 2047 to 0.
- R8: A refresh requested during an access never interrupts it; the refresh starts once the controller is idle, ahead of any waiting request, and `req_ready` stays low while it runs.
- R9: `dq_oe` is high only while `col_stb_n` and `wr_en_n` are both low.
- R10: A `refresh_interval` of 0 stops all refresh activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| refresh_interval | input | 16 | Cycles between refresh requests, 0 disables |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller takes a request on this edge |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 22 | Word address: row in [21:11], column in [10:0] |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 4 | Read data |
| mem_addr | output | 11 | Shared row/column address lines |
| row_stb_n | output | 1 | Row strobe, active low |
| col_stb_n | output | 1 | Column strobe, active low |
| wr_en_n | output | 1 | Write enable, active low |
| rd_en_n | output | 1 | Read (output) enable, active low |
| dq_o | output | 4 | Data toward the array |
| dq_oe | output | 1 | Data drive enable toward the array |
| dq_i | input | 4 | Data from the array |

## Verification
The array model in the bench drains a cell to zero whenever it is read. A missing or misdirected write-back therefore shows up as a zero on the second read of the same address. Distinct values go to addresses at the extreme rows and columns (0 and 2047 in each half) and to alternating-bit patterns, so a swapped or shifted address half lands the data in the wrong cell. Refresh is tried disabled, at a short interval interleaved with back-to-back accesses so that requests collide with pending refreshes, and long enough for the row counter to wrap. These runs separate priority, blocking and counter faults.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_RD_COL,
    ST_RESTORE,
    ST_WR_COL,
    ST_REF_ROW,
    ST_REF_HOLD,
    ST_PRE
  } seq_state_t;

  typedef enum logic [1:0] {
    ASEL_NONE,
    ASEL_ROW,
    ASEL_COL,
    ASEL_REF
  } addr_sel_t;

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int INT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INT_W-1:0] interval,
  input  logic             ack,
  output logic             pending
);
  logic [INT_W-1:0] cnt;
  logic             tick;
  logic             enabled;

  assign enabled = (interval != '0);
  assign tick    = enabled && (cnt == interval - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      if (!enabled || tick) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
      pending <= tick | (pending & ~ack);
    end
  end
endmodule

// File: rtl/dram_row_counter.sv
module dram_row_counter #(
  parameter int ROW_W = 11,
  parameter int ROWS  = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [ROW_W-1:0] row
);
  logic [ROW_W-1:0] row_next;

  generate
    if (ROWS == (1 << ROW_W)) begin : g_natural_wrap
      assign row_next = row + 1'b1;
    end else begin : g_compare_wrap
      localparam logic [ROW_W-1:0] LAST = ROW_W'(ROWS - 1);
      assign row_next = (row == LAST) ? '0 : row + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    row <= '0;
    else if (step) row <= row_next;
  end
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int COL_W = 11,
  localparam int BUS_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  addr_sel_t        sel,
  input  logic [ROW_W-1:0] acc_row,
  input  logic [COL_W-1:0] acc_col,
  input  logic [ROW_W-1:0] ref_row,
  output logic [BUS_W-1:0] bus
);
  always_comb begin
    unique case (sel)
      ASEL_ROW: bus = BUS_W'(acc_row);
      ASEL_COL: bus = BUS_W'(acc_col);
      ASEL_REF: bus = BUS_W'(ref_row);
      default:  bus = '0;
    endcase
  end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 11,
  parameter int DATA_W = 4,
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_pending,
  output logic              ref_ack,
  output logic              ref_done,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output addr_sel_t         addr_sel,
  output logic [ROW_W-1:0]  acc_row,
  output logic [COL_W-1:0]  acc_col,
  output logic              row_stb_n,
  output logic              col_stb_n,
  output logic              wr_en_n,
  output logic              rd_en_n,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_i
);
  seq_state_t        state, state_nx;
  logic              is_write;
  logic [DATA_W-1:0] wr_hold;
  logic [DATA_W-1:0] rd_hold;
  logic              accept;

  assign req_ready = (state == ST_IDLE) && !ref_pending;
  assign ref_ack   = (state == ST_IDLE) && ref_pending;
  assign ref_done  = (state == ST_REF_HOLD);
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: begin
        if (ref_pending)    state_nx = ST_REF_ROW;
        else if (req_valid) state_nx = ST_ROW;
      end
      ST_ROW:      state_nx = is_write ? ST_WR_COL : ST_RD_COL;
      ST_RD_COL:   state_nx = ST_RESTORE;
      ST_RESTORE:  state_nx = ST_PRE;
      ST_WR_COL:   state_nx = ST_PRE;
      ST_REF_ROW:  state_nx = ST_REF_HOLD;
      ST_REF_HOLD: state_nx = ST_PRE;
      default:     state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      is_write  <= 1'b0;
      acc_row   <= '0;
      acc_col   <= '0;
      wr_hold   <= '0;
      rd_hold   <= '0;
      rsp_valid <= 1'b0;
    end else begin
      state     <= state_nx;
      rsp_valid <= (state == ST_RD_COL);
      if (accept) begin
        is_write <= req_write;
        acc_row  <= req_addr[ADDR_W-1:COL_W];
        acc_col  <= req_addr[COL_W-1:0];
        wr_hold  <= req_wdata;
      end
      if (state == ST_RD_COL) rd_hold <= dq_i;
    end
  end

  assign rsp_rdata = rd_hold;

  always_comb begin
    row_stb_n = 1'b1;
    col_stb_n = 1'b1;
    wr_en_n   = 1'b1;
    rd_en_n   = 1'b1;
    dq_oe     = 1'b0;
    dq_o      = '0;
    addr_sel  = ASEL_NONE;
    unique case (state)
      ST_ROW: begin
        row_stb_n = 1'b0;
        addr_sel  = ASEL_ROW;
      end
      ST_RD_COL: begin
        row_stb_n = 1'b0;
        col_stb_n = 1'b0;
        rd_en_n   = 1'b0;
        addr_sel  = ASEL_COL;
      end
      ST_RESTORE: begin
        row_stb_n = 1'b0;
        col_stb_n = 1'b0;
        wr_en_n   = 1'b0;
        dq_oe     = 1'b1;
        dq_o      = rd_hold;
        addr_sel  = ASEL_COL;
      end
      ST_WR_COL: begin
        row_stb_n = 1'b0;
        col_stb_n = 1'b0;
        wr_en_n   = 1'b0;
        dq_oe     = 1'b1;
        dq_o      = wr_hold;
        addr_sel  = ASEL_COL;
      end
      ST_REF_ROW, ST_REF_HOLD: begin
        row_stb_n = 1'b0;
        addr_sel  = ASEL_REF;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 11,
  parameter int DATA_W = 4,
  parameter int INT_W  = 16,
  parameter int ROWS   = 2048,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int BUS_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  refresh_interval,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [BUS_W-1:0]  mem_addr,
  output logic              row_stb_n,
  output logic              col_stb_n,
  output logic              wr_en_n,
  output logic              rd_en_n,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_i
);
  logic             ref_pending, ref_ack, ref_done;
  logic [ROW_W-1:0] ref_row, acc_row;
  logic [COL_W-1:0] acc_col;
  addr_sel_t        addr_sel;

  dram_refresh_timer #(.INT_W(INT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .interval(refresh_interval),
    .ack(ref_ack), .pending(ref_pending)
  );

  dram_row_counter #(.ROW_W(ROW_W), .ROWS(ROWS)) u_rowcnt (
    .clk(clk), .rst_n(rst_n), .step(ref_done), .row(ref_row)
  );

  dram_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .ref_pending(ref_pending), .ref_ack(ref_ack), .ref_done(ref_done),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .addr_sel(addr_sel), .acc_row(acc_row), .acc_col(acc_col),
    .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
    .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
    .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
  );

  dram_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W)) u_amux (
    .sel(addr_sel), .acc_row(acc_row), .acc_col(acc_col),
    .ref_row(ref_row), .bus(mem_addr)
  );
endmodule

// File: rtl/dram_ctrl_chk.sv
module dram_ctrl_chk #(
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              row_stb_n,
  input logic              col_stb_n,
  input logic              wr_en_n,
  input logic              rd_en_n,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_oe,
  input logic [DATA_W-1:0] dq_i
);
  // R2: a column strobe only ever appears inside an open row
  p_col_in_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !col_stb_n |-> !row_stb_n);

  // R3: after acceptance the next cycle opens a row and ready is low
  p_accept_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!row_stb_n && !req_ready));

  // R5: read data strobe lasts a single cycle and follows a read column phase
  p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_rsp_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(!rd_en_n && !col_stb_n));

  // R6: the cycle after a read column phase writes the sensed value back
  p_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_n && !col_stb_n) |=> (!col_stb_n && !wr_en_n && dq_oe && dq_o == $past(dq_i)));

  // R8: no request is taken while any row is open
  p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (row_stb_n && col_stb_n));

  // R9: data is driven only in a write column phase
  p_dq_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!col_stb_n && !wr_en_n && rd_en_n));
endmodule

bind dram_ctrl dram_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
  .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
  .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
);

// File: tb/dram_ctrl_bench.sv
module dram_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] refresh_interval = 16'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [3:0]  rsp_rdata;
  logic [10:0] mem_addr;
  logic        row_stb_n, col_stb_n, wr_en_n, rd_en_n, dq_oe;
  logic [3:0]  dq_o, dq_i;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  dram_ctrl u_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .refresh_interval(refresh_interval),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
    .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
    .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
  );

  // Array model: cells indexed by the low 3 bits of row and column.
  // A read leaves the cell at zero until something writes it again.
  logic [3:0]  cells [64];
  logic [10:0] open_row = '0;
  logic        prev_row_n = 1'b1;
  logic        col_seen = 1'b0;
  logic [10:0] last_row = '0, last_col = '0;
  int          ref_events = 0;
  int          ref_bad = 0;
  int          dq_bad = 0;
  logic [10:0] ref_expect = '0;
  logic [5:0]  cell_idx;

  assign cell_idx = {open_row[2:0], mem_addr[2:0]};
  assign dq_i = (!col_stb_n && !rd_en_n) ? cells[cell_idx] : 4'h0;

  initial for (int i = 0; i < 64; i++) cells[i] = 4'h0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (!row_stb_n && prev_row_n) begin
        open_row <= mem_addr;
        last_row <= mem_addr;
        col_seen <= 1'b0;
      end
      if (!col_stb_n) begin
        col_seen <= 1'b1;
        last_col <= mem_addr;
        if (!rd_en_n)            cells[cell_idx] <= 4'h0;
        if (!wr_en_n && dq_oe)   cells[cell_idx] <= dq_o;
      end
      if (dq_oe && (col_stb_n || wr_en_n)) dq_bad <= dq_bad + 1;
      if (row_stb_n && !prev_row_n && !col_seen) begin
        ref_events <= ref_events + 1;
        if (open_row != ref_expect) ref_bad <= ref_bad + 1;
        ref_expect <= ref_expect + 11'd1;
      end
      prev_row_n <= row_stb_n;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic txn(input logic wr, input logic [10:0] row, input logic [10:0] col,
                     input logic [3:0] wd, output logic [3:0] rd);
    int guard;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = {row, col}; req_wdata = wd;
    guard = 0;
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
    req_valid = 1'b0;
    rd = 4'h0;
    if (!wr) begin
      guard = 0;
      while (!rsp_valid && guard < 20) begin @(negedge clk); guard++; end
      rd = rsp_rdata;
      @(negedge clk);
      check("R5 single-cycle rsp_valid", {31'd0, rsp_valid}, 32'd0);
    end
    while (!row_stb_n) @(negedge clk);
  endtask

  // {write, row, col, data}; reads expect data
  localparam int NV = 12;
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 11'h000, 11'h000, 4'h5},
    {1'b1, 11'h7FF, 11'h001, 4'hA},
    {1'b1, 11'h001, 11'h7FF, 4'h3},
    {1'b1, 11'h2AA, 11'h555, 4'hC},
    {1'b0, 11'h000, 11'h000, 4'h5},
    {1'b0, 11'h7FF, 11'h001, 4'hA},
    {1'b0, 11'h001, 11'h7FF, 4'h3},
    {1'b0, 11'h2AA, 11'h555, 4'hC},
    {1'b0, 11'h7FF, 11'h001, 4'hA},
    {1'b0, 11'h2AA, 11'h555, 4'hC},
    {1'b0, 11'h000, 11'h000, 4'h5},
    {1'b0, 11'h001, 11'h7FF, 4'h3}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [3:0] rd;
    int base;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 row strobe idle", {31'd0, row_stb_n}, 32'd1);
    check("R1 col strobe idle", {31'd0, col_stb_n}, 32'd1);
    check("R1 enables idle", {30'd0, wr_en_n, rd_en_n}, 32'd3);
    check("R1 outputs low", {30'd0, dq_oe, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", {31'd0, req_ready}, 32'd1);

    // Vector walk (R2, R4, R5, R6), refresh disabled (R10)
    for (int v = 0; v < NV; v++) begin
      txn(VEC[v][26], VEC[v][25:15], VEC[v][14:4], VEC[v][3:0], rd);
      check("R2 row half", {21'd0, last_row}, {21'd0, VEC[v][25:15]});
      check("R2 col half", {21'd0, last_col}, {21'd0, VEC[v][14:4]});
      if (!VEC[v][26]) check(v >= 8 ? "R6 repeated read" : "R4 read after write",
                             {28'd0, rd}, {28'd0, VEC[v][3:0]});
    end

    // R3: back-pressure, ready low through the access
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = {11'h003, 11'h006}; req_wdata = 4'h9;
    @(negedge clk);
    req_valid = 1'b0;
    check("R3 ready low in row phase", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    check("R4 write column phase", {29'd0, col_stb_n, wr_en_n, dq_oe}, 32'd1);
    check("R4 write data driven", {28'd0, dq_o}, 32'h9);
    check("R3 ready low in column phase", {31'd0, req_ready}, 32'd0);
    repeat (4) @(negedge clk);
    txn(1'b0, 11'h003, 11'h006, 4'h0, rd);
    check("R3 single write landed", {28'd0, rd}, 32'h9);
    check("R10 no refresh when disabled", ref_events, 32'd0);
    check("R9 data drive only in write column", dq_bad, 32'd0);

    // R8: refresh interleaved with back-to-back accesses
    refresh_interval = 16'd5;
    base = ref_events;
    for (int k = 0; k < 8; k++) begin
      txn(1'b1, 11'h004, 11'(k), 4'(k + 1), rd);
      txn(1'b0, 11'h004, 11'(k), 4'h0, rd);
      check("R8 access intact around refresh", {28'd0, rd}, {28'd0, 4'(k + 1)});
    end
    check("R8 refreshes ran between accesses", {31'd0, (ref_events > base + 4)}, 32'd1);
    check("R7 refresh row order", ref_bad, 32'd0);

    // R7: refresh with no traffic, long enough for the counter to wrap
    refresh_interval = 16'd6;
    while (ref_events < 2060) @(negedge clk);
    check("R7 row counter wraps in order", ref_bad, 32'd0);
    txn(1'b0, 11'h2AA, 11'h555, 4'h0, rd);
    check("R6 data survives refresh", {28'd0, rd}, 32'hC);
    check("R9 data drive only in write column", dq_bad, 32'd0);

    // R10: interval back to 0 stops refresh
    refresh_interval = 16'd0;
    repeat (12) @(negedge clk);
    base = ref_events;
    repeat (50) @(negedge clk);
    check("R10 refresh stops", ref_events, base);
    check("R1 idle ready without refresh", {31'd0, req_ready}, 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule